// File: doc/BRIEF.md
# Compare-Selected Condition Branch Unit

This unit resolves conditional branches for a simple in-order core in which the compare instruction carries the branch condition. When a compare is issued, the unit subtracts the second operand from the first. It forms zero, negative, carry and overflow flags from the result. A 3-bit select code on the same instruction picks one condition derived from those flags, and that single bit is stored.

A later conditional branch does not decode any condition of its own. It reads the stored bit and, in the same cycle, chooses between its target address and the sequential address `pc_i + 1`. The branch therefore resolves in one cycle and needs no delay slot. The current PC is supplied by the fetch logic, which stays outside this block and consumes `next_pc_o`.

Top module: `cmp_branch_unit`

## Requirements
- R1: A compare forms `op_a_i - op_b_i` over DATA_W bits and derives four flags. Zero is set when the operands are equal. Negative is the top bit of the difference. Carry is set when no borrow occurs, that is when `op_a_i >= op_b_i` unsigned. Overflow is set when the signed difference does not fit in DATA_W bits.
- R2: The select code `cmp_sel_i` maps to these conditions: 0 = zero, 1 = not zero, 2 = negative, 3 = carry, 4 = overflow, 5 = signed `op_a_i < op_b_i`, 6 = unsigned `op_a_i < op_b_i`, 7 = always true.
- R3: When `cmp_valid_i` is high at a rising clock edge, the selected condition bit is stored. A branch sees the new bit from the following cycle on.
- R4: While `cmp_valid_i` is low, the stored bit keeps its value. Changes on `op_a_i`, `op_b_i`, `cmp_sel_i`, and branches themselves, have no effect on it.
- R5: When `br_valid_i` is high and the stored bit is 1, `taken_o` is 1 and `next_pc_o` equals `br_target_i` combinationally in that same cycle.
- R6: When `br_valid_i` is low, or the stored bit is 0, `taken_o` is 0 and `next_pc_o` equals `pc_i + 1` modulo 2^ADDR_W.
- R7: Reset clears the stored bit, so a branch before any compare is not taken.
- R8: When a compare and a branch arrive in the same cycle, the branch uses the bit stored before that compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_valid_i | input | 1 | Compare instruction strobe |
| cmp_sel_i | input | 3 | Condition select code carried by the compare |
| op_a_i | input | DATA_W | First compare operand (minuend) |
| op_b_i | input | DATA_W | Second compare operand (subtrahend) |
| br_valid_i | input | 1 | Conditional branch strobe |
| br_target_i | input | ADDR_W | Branch target address |
| pc_i | input | ADDR_W | Address of the current instruction |
| next_pc_o | output | ADDR_W | Next fetch address |
| taken_o | output | 1 | Branch taken |

## Verification
The stored condition bit changes at the clock edge on which a compare is sampled. The branch outputs are purely combinational from the branch inputs and that bit.

The bench drives every input on the falling edge. It checks `taken_o` and `next_pc_o` 1 ns later in the same half cycle, so branch results are seen with zero cycles of latency. A compare's effect is checked with a branch issued in the cycle immediately after the edge that stored it. The same-cycle case checks that the branch still sees the old bit before that edge.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef enum logic [2:0] {
    SEL_ZERO   = 3'd0,
    SEL_NZERO  = 3'd1,
    SEL_NEG    = 3'd2,
    SEL_CARRY  = 3'd3,
    SEL_OVF    = 3'd4,
    SEL_SLT    = 3'd5,
    SEL_ULT    = 3'd6,
    SEL_ALWAYS = 3'd7
  } cond_sel_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cbu_subtractor.sv
module cbu_subtractor #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output cbu_pkg::flags_t   flags_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] diff;

  assign wide = {1'b0, a_i} - {1'b0, b_i};
  assign diff = wide[MSB:0];

  assign flags_o.z = (diff == '0);
  assign flags_o.n = diff[MSB];
  assign flags_o.c = ~wide[DATA_W];  // no borrow
  assign flags_o.v = (a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ diff[MSB]);
endmodule

// File: rtl/cbu_cond_select.sv
module cbu_cond_select (
  input  cbu_pkg::flags_t flags_i,
  input  logic [2:0]      sel_i,
  output logic            cond_o
);
  import cbu_pkg::*;

  always_comb begin
    unique case (cond_sel_e'(sel_i))
      SEL_ZERO:   cond_o = flags_i.z;
      SEL_NZERO:  cond_o = ~flags_i.z;
      SEL_NEG:    cond_o = flags_i.n;
      SEL_CARRY:  cond_o = flags_i.c;
      SEL_OVF:    cond_o = flags_i.v;
      SEL_SLT:    cond_o = flags_i.n ^ flags_i.v;
      SEL_ULT:    cond_o = ~flags_i.c;
      default:    cond_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cbu_cond_latch.sv
module cbu_cond_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic cond_i,
  output logic bit_o
);
  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bit_q <= 1'b0;
    else if (load_i) bit_q <= cond_i;
  end

  assign bit_o = bit_q;

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(bit_q))
    else $error("stored condition changed without a compare");
endmodule

// File: rtl/cbu_next_pc.sv
module cbu_next_pc #(
  parameter int ADDR_W = 16
) (
  input  logic              br_valid_i,
  input  logic              cond_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              taken_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  assign taken_o   = br_valid_i & cond_i;
  assign next_pc_o = taken_o ? target_i : pc_i + ONE;
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_valid_i,
  input  logic [2:0]        cmp_sel_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              br_valid_i,
  input  logic [ADDR_W-1:0] br_target_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              taken_o
);
  import cbu_pkg::*;

  flags_t flags;
  logic   cond_sel;
  logic   cond_q;

  cbu_subtractor #(.DATA_W(DATA_W)) u_sub (
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .flags_o (flags)
  );

  cbu_cond_select u_sel (
    .flags_i (flags),
    .sel_i   (cmp_sel_i),
    .cond_o  (cond_sel)
  );

  cbu_cond_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmp_valid_i),
    .cond_i (cond_sel),
    .bit_o  (cond_q)
  );

  cbu_next_pc #(.ADDR_W(ADDR_W)) u_npc (
    .br_valid_i (br_valid_i),
    .cond_i     (cond_q),
    .target_i   (br_target_i),
    .pc_i       (pc_i),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o)
  );

  p_eq_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i && cmp_sel_i == 3'd0 && op_a_i == op_b_i |=> cond_q)
    else $error("equal operands did not store zero condition");

  p_always_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i && cmp_sel_i == 3'd7 |=> cond_q)
    else $error("always-true select did not store 1");

  p_load_ult_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i && cmp_sel_i == 3'd6 |=> cond_q == $past(op_a_i < op_b_i))
    else $error("unsigned less-than not stored");

  p_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_i && cond_q |-> taken_o && next_pc_o == br_target_i)
    else $error("branch with set condition not taken");

  p_seq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br_valid_i && cond_q) |-> !taken_o && next_pc_o == pc_i + ADDR_W'(1))
    else $error("sequential address wrong");
endmodule

// File: tb/sim_cmp_branch_unit.sv
module sim_cmp_branch_unit;
  localparam int DW = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_valid = 1'b0;
  logic [2:0]    cmp_sel = '0;
  logic [DW-1:0] op_a = '0;
  logic [DW-1:0] op_b = '0;
  logic          br_valid = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic [AW-1:0] pc = '0;
  logic [AW-1:0] next_pc;
  logic          taken;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_branch_unit #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmp_valid_i (cmp_valid),
    .cmp_sel_i   (cmp_sel),
    .op_a_i      (op_a),
    .op_b_i      (op_b),
    .br_valid_i  (br_valid),
    .br_target_i (br_target),
    .pc_i        (pc),
    .next_pc_o   (next_pc),
    .taken_o     (taken)
  );

  function automatic logic exp_cond(logic [DW-1:0] a, logic [DW-1:0] b, logic [2:0] s);
    int sa = int'($signed(a));
    int sb = int'($signed(b));
    int sd = sa - sb;
    logic [DW-1:0] d = a - b;
    case (s)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return d[DW-1];
      3'd3: return a >= b;
      3'd4: return (sd > 32767) || (sd < -32768);
      3'd5: return sa < sb;
      3'd6: return a < b;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(bit ok, string req, longint got, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_cmp(logic [DW-1:0] a, logic [DW-1:0] b, logic [2:0] s);
    @(negedge clk);
    op_a = a; op_b = b; cmp_sel = s; cmp_valid = 1'b1;
    @(posedge clk);
    #1 cmp_valid = 1'b0;
  endtask

  task automatic br_check(logic [AW-1:0] p, logic [AW-1:0] t, bit exp_t, string req);
    logic [AW-1:0] exp_pc = exp_t ? t : p + AW'(1);
    @(negedge clk);
    pc = p; br_target = t; br_valid = 1'b1;
    #1;
    check(taken == exp_t, req, taken, exp_t);
    check(next_pc == exp_pc, req, next_pc, exp_pc);
    #1 br_valid = 1'b0;
  endtask

  task automatic t_reset();
    br_check(16'h0010, 16'h0200, 1'b0, "R7 branch before any compare");
    do_cmp(16'd1, 16'd1, 3'd7);
    br_check(16'h0011, 16'h0300, 1'b1, "R3 stored after compare");
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    br_check(16'h0012, 16'h0400, 1'b0, "R7 reset clears stored bit");
  endtask

  task automatic t_cond_codes();
    logic [DW-1:0] va [7] = '{16'd5, 16'd3, 16'd7, 16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF};
    logic [DW-1:0] vb [7] = '{16'd5, 16'd7, 16'd3, 16'h0001, 16'hFFFF, 16'hFFFF, 16'h0000};
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 7; i++) begin
        logic e = exp_cond(va[i], vb[i], 3'(s));
        do_cmp(va[i], vb[i], 3'(s));
        br_check(16'h1000 + AW'(i), 16'h2000 + AW'(s), e,
                 $sformatf("R1/R2 sel %0d pair %0d", s, i));
      end
    end
  endtask

  task automatic t_hold();
    do_cmp(16'd9, 16'd9, 3'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      op_a = 16'd1; op_b = 16'd2; cmp_sel = 3'd0;
    end
    br_check(16'h0040, 16'h0500, 1'b1, "R4 operand change without compare");
    br_check(16'h0041, 16'h0501, 1'b1, "R4 branch leaves stored bit");
  endtask

  task automatic t_same_cycle();
    do_cmp(16'd4, 16'd4, 3'd0);
    @(negedge clk);
    op_a = 16'd1; op_b = 16'd2; cmp_sel = 3'd0; cmp_valid = 1'b1;
    pc = 16'h0050; br_target = 16'h0700; br_valid = 1'b1;
    #1;
    check(taken == 1'b1, "R8 same-cycle branch uses old bit", taken, 1);
    check(next_pc == 16'h0700, "R8 same-cycle target", next_pc, 16'h0700);
    @(posedge clk);
    #1 cmp_valid = 1'b0; br_valid = 1'b0;
    br_check(16'h0051, 16'h0701, 1'b0, "R3 new bit after same-cycle compare");
  endtask

  task automatic t_seq();
    do_cmp(16'd0, 16'd0, 3'd7);
    @(negedge clk);
    pc = 16'h0123; br_target = 16'h0999; br_valid = 1'b0;
    #1;
    check(taken == 1'b0, "R6 no branch strobe", taken, 0);
    check(next_pc == 16'h0124, "R6 no branch strobe pc", next_pc, 16'h0124);
    do_cmp(16'd2, 16'd1, 3'd0);
    br_check(16'hFFFF, 16'h0800, 1'b0, "R6 sequential wrap");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_cond_codes();
    t_hold();
    t_same_cycle();
    t_seq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule